// File: doc/BRIEF.md
# UART Channel-Mode Router with Receive FIFO

This block sits between the serial receiver, the serial transmitter and the host data register of a UART. A two-bit channel mode decides where each byte goes. Bytes from the line can be stored for the host, sent back out on the line, or both. Bytes written by the host can be sent out on the line, looped straight into the receive store, or dropped.

The block also owns the receive FIFO. The FIFO only takes or gives up bytes while receive is switched on. It reports an overrun when a byte arrives with no room left. It also raises a timeout pulse when the line has been quiet for a set number of character times after the last byte was stored.

The host side sees the data read port, the FIFO fill count and the two event pulses. The serial shifters sit outside this block. They supply a byte-valid strobe, a line-break strobe and a once-per-character-time tick.

Top module: `uart_chmode_rx`

## Requirements
- R1: `mode_i` uses the codes 0 = normal, 1 = echo, 2 = local loopback and 3 = remote loopback. A line byte (`line_vld_i`) is stored in the FIFO in modes 0 and 1. It is presented on `tx_vld_o`/`tx_byte_o` in the following cycle in modes 1 and 3.
- R2: A host write (`host_wr_i`) is presented on the transmit output in the following cycle in mode 0. It is stored in the FIFO in mode 2. In modes 1 and 3 it is dropped, and neither the FIFO nor the transmit output changes.
- R3: Receive is active only when `rx_en_i` = 1 and `rx_dis_i` = 0. While receive is inactive, bytes bound for the FIFO are discarded without an overrun. A host read does not remove a byte and returns 0. Forwarding of bytes to the transmit output is not gated by these two bits.
- R4: The FIFO returns bytes in arrival order on `host_rdata_o`, in the cycle after `host_rd_i`. `rx_count_o` shows the fill level one cycle after a store or a read, and holds values up to DEPTH.
- R5: A byte bound for the FIFO while `rx_count_o` = DEPTH is dropped. `ovr_o` then pulses high for one cycle in the following cycle, and the stored contents are unchanged.
- R6: A host read of an empty FIFO returns 0, and the count stays 0.
- R7: Each byte stored in the FIFO restarts a timer. `tmo_o` pulses for one cycle in the cycle after the fourth `char_tick_i` that follows the last stored byte. After that pulse the timer stays idle until the next byte is stored.
- R8: If `tmo_en_i` (a nonzero timeout setting) is 0 when the timer expires, no pulse is produced and the timer goes idle.
- R9: A line break (`line_brk_i`) stores a zero byte in the FIFO in every mode while receive is active, and is never sent to the transmit output. A break takes priority over any other byte bound for the FIFO in the same cycle, and that other byte is lost.
- R10: `rx_rst_i` empties the FIFO and cancels the timer. The count reads 0 in the next cycle, and any store or read in the same cycle is ignored.
- R11: After the synchronous reset, `rx_count_o` is 0 and `tx_vld_o`, `ovr_o` and `tmo_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Channel mode (0 normal, 1 echo, 2 local loopback, 3 remote loopback) |
| rx_en_i | input | 1 | Receive enable control bit |
| rx_dis_i | input | 1 | Receive disable control bit |
| rx_rst_i | input | 1 | Receive FIFO flush, one-cycle pulse |
| tmo_en_i | input | 1 | High when the timeout setting is nonzero |
| char_tick_i | input | 1 | One pulse per character time |
| line_vld_i | input | 1 | Received byte valid |
| line_byte_i | input | DATA_W | Received byte |
| line_brk_i | input | 1 | Line break detected |
| host_wr_i | input | 1 | Host write to the data register |
| host_wdata_i | input | DATA_W | Host write data |
| host_rd_i | input | 1 | Host read of the data register |
| host_rdata_o | output | DATA_W | Read data, valid the cycle after the read |
| tx_vld_o | output | 1 | Byte for the transmitter valid |
| tx_byte_o | output | DATA_W | Byte for the transmitter |
| rx_count_o | output | $clog2(DEPTH+1) | FIFO fill count |
| ovr_o | output | 1 | Overrun pulse |
| tmo_o | output | 1 | Receive timeout pulse |

## Verification
The bench builds the block with DEPTH = 8 and TMO_CHARS = 4. The small depth lets the tests fill the FIFO, trigger the overrun and drain it again with a few dozen writes. This exercises the full and empty edges and the pointer wrap with each byte's order checked. With the four-tick timer, the tests can restart the timer partway through a count and place the expiry exactly. The tests also walk all four modes with both line bytes and host writes, and check the break and flush priorities.

// File: rtl/uart_chmode_pkg.sv
package uart_chmode_pkg;
  typedef enum logic [1:0] {
    CHM_NORMAL = 2'd0,
    CHM_ECHO   = 2'd1,
    CHM_LOCAL  = 2'd2,
    CHM_REMOTE = 2'd3
  } chmode_e;

  function automatic logic line_stores(chmode_e m);
    return (m == CHM_NORMAL) || (m == CHM_ECHO);
  endfunction

  function automatic logic line_echoes(chmode_e m);
    return (m == CHM_ECHO) || (m == CHM_REMOTE);
  endfunction
endpackage

// File: rtl/uart_mode_route.sv
module uart_mode_route
  import uart_chmode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  chmode_e           mode,
  input  logic              line_vld,
  input  logic [DATA_W-1:0] line_byte,
  input  logic              line_brk,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              fifo_req,
  output logic [DATA_W-1:0] fifo_data,
  output logic              tx_vld,
  output logic [DATA_W-1:0] tx_byte
);
  logic              tx_req;
  logic [DATA_W-1:0] tx_data;

  // FIFO source: break first, then line byte, then host loopback write
  always_comb begin
    fifo_req  = 1'b0;
    fifo_data = '0;
    if (line_brk) begin
      fifo_req = 1'b1;
    end else if (line_vld && line_stores(mode)) begin
      fifo_req  = 1'b1;
      fifo_data = line_byte;
    end else if (host_wr && (mode == CHM_LOCAL)) begin
      fifo_req  = 1'b1;
      fifo_data = host_wdata;
    end
  end

  // Transmit source: line echo and host normal write never coexist
  always_comb begin
    tx_req  = 1'b0;
    tx_data = '0;
    if (line_vld && line_echoes(mode)) begin
      tx_req  = 1'b1;
      tx_data = line_byte;
    end else if (host_wr && (mode == CHM_NORMAL)) begin
      tx_req  = 1'b1;
      tx_data = host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_vld  <= 1'b0;
      tx_byte <= '0;
    end else begin
      tx_vld  <= tx_req;
      tx_byte <= tx_data;
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              active,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              pushed,
  output logic [DATA_W-1:0] rdata,
  output logic [CW-1:0]     count,
  output logic              ovr
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ram_q;
  logic [AW-1:0]     wptr, rptr;
  logic              take_q;
  logic              full, empty, push, pop;

  assign full   = (count == FULL);
  assign empty  = (count == '0);
  assign push   = !flush && active && wr_req && !full;
  assign pop    = !flush && active && rd_req && !empty;
  assign pushed = push;

  // Storage array: write port and registered read port only
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (pop) ram_q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr   <= '0;
      rptr   <= '0;
      count  <= '0;
      take_q <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      take_q <= pop;
      ovr    <= active && wr_req && full;
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = take_q ? ram_q : '0;
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
  parameter int TMO_CHARS = 4,
  localparam int TW       = $clog2(TMO_CHARS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic restart,
  input  logic tick,
  input  logic enable,
  output logic tmo
);
  localparam logic [TW-1:0] LAST = TW'(TMO_CHARS - 1);

  logic          armed;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      armed <= 1'b0;
      cnt   <= '0;
      tmo   <= 1'b0;
    end else begin
      tmo <= 1'b0;
      if (restart) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed && tick) begin
        if (cnt == LAST) begin
          armed <= 1'b0;
          cnt   <= '0;
          tmo   <= enable;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_chmode_rx.sv
module uart_chmode_rx
  import uart_chmode_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 64,
  parameter int TMO_CHARS = 4,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic              rx_en_i,
  input  logic              rx_dis_i,
  input  logic              rx_rst_i,
  input  logic              tmo_en_i,
  input  logic              char_tick_i,
  input  logic              line_vld_i,
  input  logic [DATA_W-1:0] line_byte_i,
  input  logic              line_brk_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_rd_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              tx_vld_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic [CW-1:0]     rx_count_o,
  output logic              ovr_o,
  output logic              tmo_o
);
  logic              rx_active;
  logic              fifo_req, pushed;
  logic [DATA_W-1:0] fifo_data;

  assign rx_active = rx_en_i && !rx_dis_i;

  uart_mode_route #(.DATA_W(DATA_W)) u_route (
    .clk        (clk),
    .rst        (rst),
    .mode       (chmode_e'(mode_i)),
    .line_vld   (line_vld_i),
    .line_byte  (line_byte_i),
    .line_brk   (line_brk_i),
    .host_wr    (host_wr_i),
    .host_wdata (host_wdata_i),
    .fifo_req   (fifo_req),
    .fifo_data  (fifo_data),
    .tx_vld     (tx_vld_o),
    .tx_byte    (tx_byte_o)
  );

  uart_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .flush   (rx_rst_i),
    .active  (rx_active),
    .wr_req  (fifo_req),
    .wr_data (fifo_data),
    .rd_req  (host_rd_i),
    .pushed  (pushed),
    .rdata   (host_rdata_o),
    .count   (rx_count_o),
    .ovr     (ovr_o)
  );

  uart_rx_timeout #(.TMO_CHARS(TMO_CHARS)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .flush   (rx_rst_i),
    .restart (pushed),
    .tick    (char_tick_i),
    .enable  (tmo_en_i),
    .tmo     (tmo_o)
  );
endmodule

// File: rtl/uart_chmode_rx_chk.sv
module uart_chmode_rx_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    mode_i,
  input logic          rx_en_i,
  input logic          rx_dis_i,
  input logic          rx_rst_i,
  input logic          tx_vld_o,
  input logic [CW-1:0] rx_count_o,
  input logic          ovr_o,
  input logic          tmo_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    rx_count_o <= FULL); // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_rst_i) |-> (rx_count_o == $past(rx_count_o)) ||
                         (rx_count_o == $past(rx_count_o) + 1'b1) ||
                         (rx_count_o == $past(rx_count_o) - 1'b1)); // R4

  AST_LOCAL_NO_TX: assert property (@(posedge clk) disable iff (rst)
    tx_vld_o |-> $past(mode_i) != 2'd2); // R1

  AST_OVR_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    ovr_o |-> $past(rx_count_o) == FULL); // R5

  AST_OVR_NO_GROW: assert property (@(posedge clk) disable iff (rst)
    ovr_o |-> rx_count_o <= $past(rx_count_o)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ($past(!rx_en_i || rx_dis_i) && !$past(rx_rst_i)) |->
      rx_count_o == $past(rx_count_o)); // R3

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    $past(rx_rst_i) |-> rx_count_o == '0); // R10

  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tmo_o |=> !tmo_o); // R7
endmodule

bind uart_chmode_rx uart_chmode_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_i     (mode_i),
  .rx_en_i    (rx_en_i),
  .rx_dis_i   (rx_dis_i),
  .rx_rst_i   (rx_rst_i),
  .tx_vld_o   (tx_vld_o),
  .rx_count_o (rx_count_o),
  .ovr_o      (ovr_o),
  .tmo_o      (tmo_o)
);

// File: tb/tb_uart_chmode_rx.sv
module tb_uart_chmode_rx;
  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int TMO   = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    mode_i;
  logic          rx_en_i, rx_dis_i, rx_rst_i, tmo_en_i, char_tick_i;
  logic          line_vld_i, line_brk_i, host_wr_i, host_rd_i;
  logic [DW-1:0] line_byte_i, host_wdata_i, host_rdata_o, tx_byte_o;
  logic          tx_vld_o, ovr_o, tmo_o;
  logic [CW-1:0] rx_count_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  uart_chmode_rx #(.DATA_W(DW), .DEPTH(DEPTH), .TMO_CHARS(TMO)) dut (.*);

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic line_in(logic [7:0] b);
    line_vld_i = 1'b1; line_byte_i = b;
    @(negedge clk);
    line_vld_i = 1'b0;
  endtask

  task automatic host_in(logic [7:0] b);
    host_wr_i = 1'b1; host_wdata_i = b;
    @(negedge clk);
    host_wr_i = 1'b0;
  endtask

  task automatic host_out(output logic [7:0] v);
    host_rd_i = 1'b1;
    @(negedge clk);
    host_rd_i = 1'b0;
    v = host_rdata_o;
  endtask

  task automatic tick();
    char_tick_i = 1'b1;
    @(negedge clk);
    char_tick_i = 1'b0;
  endtask

  task automatic flush();
    rx_rst_i = 1'b1;
    @(negedge clk);
    rx_rst_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R11", "count", int'(rx_count_o), 0);
    check("R11", "tx_vld", int'(tx_vld_o), 0);
    check("R11", "ovr", int'(ovr_o), 0);
    check("R11", "tmo", int'(tmo_o), 0);
  endtask

  task automatic t_line_modes();
    logic [7:0] v;
    mode_i = 2'd0; line_in(8'h11);
    check("R1", "normal tx_vld", int'(tx_vld_o), 0);
    check("R1", "normal count", int'(rx_count_o), 1);
    mode_i = 2'd1; line_in(8'h22);
    check("R1", "echo tx_vld", int'(tx_vld_o), 1);
    check("R1", "echo tx_byte", int'(tx_byte_o), 'h22);
    check("R1", "echo count", int'(rx_count_o), 2);
    mode_i = 2'd2; line_in(8'h33);
    check("R1", "local tx_vld", int'(tx_vld_o), 0);
    check("R1", "local count", int'(rx_count_o), 2);
    mode_i = 2'd3; line_in(8'h44);
    check("R1", "remote tx_byte", int'(tx_byte_o), 'h44);
    check("R1", "remote count", int'(rx_count_o), 2);
    host_out(v); check("R4", "first read", int'(v), 'h11);
    host_out(v); check("R4", "second read", int'(v), 'h22);
    check("R4", "count drained", int'(rx_count_o), 0);
  endtask

  task automatic t_host_modes();
    logic [7:0] v;
    mode_i = 2'd0; host_in(8'h55);
    check("R2", "normal tx_byte", int'(tx_byte_o), 'h55);
    check("R2", "normal count", int'(rx_count_o), 0);
    mode_i = 2'd1; host_in(8'h56);
    check("R2", "echo dropped tx", int'(tx_vld_o), 0);
    check("R2", "echo dropped count", int'(rx_count_o), 0);
    mode_i = 2'd2; host_in(8'h66);
    check("R2", "local tx_vld", int'(tx_vld_o), 0);
    check("R2", "local count", int'(rx_count_o), 1);
    mode_i = 2'd3; host_in(8'h67);
    check("R2", "remote dropped tx", int'(tx_vld_o), 0);
    check("R2", "remote dropped count", int'(rx_count_o), 1);
    host_out(v); check("R2", "loopback byte", int'(v), 'h66);
  endtask

  task automatic t_empty();
    logic [7:0] v;
    host_out(v);
    check("R6", "empty read", int'(v), 0);
    check("R6", "empty count", int'(rx_count_o), 0);
  endtask

  task automatic t_gate();
    logic [7:0] v;
    mode_i = 2'd0; line_in(8'h12);
    rx_dis_i = 1'b1;
    line_in(8'h34);
    check("R3", "disabled count", int'(rx_count_o), 1);
    host_out(v);
    check("R3", "disabled read", int'(v), 0);
    check("R3", "disabled read count", int'(rx_count_o), 1);
    rx_dis_i = 1'b0; rx_en_i = 1'b0; mode_i = 2'd1;
    line_in(8'h77);
    check("R3", "not enabled count", int'(rx_count_o), 1);
    check("R3", "echo still out", int'(tx_byte_o), 'h77);
    rx_en_i = 1'b1;
    host_out(v);
    check("R3", "kept byte", int'(v), 'h12);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    mode_i = 2'd0;
    for (int i = 0; i < DEPTH; i++) line_in(8'(i + 1));
    check("R5", "full count", int'(rx_count_o), DEPTH);
    check("R5", "no early ovr", int'(ovr_o), 0);
    line_in(8'hEE);
    check("R5", "ovr pulse", int'(ovr_o), 1);
    check("R5", "count held", int'(rx_count_o), DEPTH);
    idle();
    check("R5", "ovr one cycle", int'(ovr_o), 0);
    for (int i = 0; i < DEPTH; i++) begin
      host_out(v);
      check("R4", "order after wrap", int'(v), i + 1);
    end
    line_in(8'hA1); line_in(8'hA2);
    host_out(v); check("R4", "wrapped pointer", int'(v), 'hA1);
    flush();
  endtask

  task automatic t_timeout();
    tmo_en_i = 1'b1; mode_i = 2'd0;
    line_in(8'h01);
    for (int i = 0; i < TMO - 1; i++) begin
      tick(); check("R7", "early tick", int'(tmo_o), 0);
    end
    line_in(8'h02);
    for (int i = 0; i < TMO - 1; i++) begin
      tick(); check("R7", "restarted", int'(tmo_o), 0);
    end
    tick();
    check("R7", "expiry pulse", int'(tmo_o), 1);
    idle();
    check("R7", "pulse width", int'(tmo_o), 0);
    for (int i = 0; i < TMO + 1; i++) begin
      tick(); check("R7", "idle after fire", int'(tmo_o), 0);
    end
    tmo_en_i = 1'b0;
    line_in(8'h03);
    for (int i = 0; i < TMO; i++) begin
      tick(); check("R8", "setting zero", int'(tmo_o), 0);
    end
    flush();
  endtask

  task automatic t_break();
    logic [7:0] v;
    mode_i = 2'd2;
    line_brk_i = 1'b1; host_wr_i = 1'b1; host_wdata_i = 8'h5A;
    @(negedge clk);
    line_brk_i = 1'b0; host_wr_i = 1'b0;
    check("R9", "break wins count", int'(rx_count_o), 1);
    mode_i = 2'd3;
    line_brk_i = 1'b1;
    @(negedge clk);
    line_brk_i = 1'b0;
    check("R9", "break not sent", int'(tx_vld_o), 0);
    check("R9", "break stored", int'(rx_count_o), 2);
    host_out(v); check("R9", "break byte 1", int'(v), 0);
    check("R9", "after read", int'(rx_count_o), 1);
    host_out(v); check("R9", "break byte 2", int'(v), 0);
    check("R9", "loopback byte lost", int'(rx_count_o), 0);
  endtask

  task automatic t_flush();
    logic [7:0] v;
    mode_i = 2'd0; tmo_en_i = 1'b1;
    line_in(8'hC1); line_in(8'hC2); line_in(8'hC3);
    rx_rst_i = 1'b1; line_vld_i = 1'b1; line_byte_i = 8'hC4;
    @(negedge clk);
    rx_rst_i = 1'b0; line_vld_i = 1'b0;
    check("R10", "flushed count", int'(rx_count_o), 0);
    host_out(v);
    check("R10", "flushed read", int'(v), 0);
    for (int i = 0; i < TMO + 1; i++) begin
      tick(); check("R10", "timer cancelled", int'(tmo_o), 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode_i = 2'd0; rx_en_i = 1'b1; rx_dis_i = 1'b0;
    rx_rst_i = 1'b0; tmo_en_i = 1'b0; char_tick_i = 1'b0;
    line_vld_i = 1'b0; line_byte_i = '0; line_brk_i = 1'b0;
    host_wr_i = 1'b0; host_wdata_i = '0; host_rd_i = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_line_modes();
    t_host_modes();
    t_empty();
    t_gate();
    t_overrun();
    t_timeout();
    t_break();
    t_flush();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule